// File: doc/BRIEF.md
# Staggered Three-Phase PWM Generator

This block drives three single-ended pulse-width-modulated outputs from one shared 8-bit duty word. Each output has its own free-running counter and its own registered comparator. The phases sit one third of a period apart.

The spacing does not come from preset counter values. Phase 2 waits, idle and low, until the counter of phase 1 first reaches the one-third mark. It then starts and keeps running, because a start flag is latched and held. Phase 3 starts from phase 2 in the same way. The duty word is turned into a compare threshold by subtracting it from the counter range.

Complementary outputs and dead-time insertion belong to a separate block placed downstream.

Top module: `pwm_stagger`

## Requirements
- R1: While synchronous reset `rst` is high, every counter, start flag and output register is cleared at each clock edge. `pwm_out` reads 3'b000 afterwards.
- R2: Each phase counter is 8 bits wide. It advances by one on every enabled clock edge while its phase runs, and it wraps from 255 to 0. The output therefore repeats with a period of exactly 256 cycles.
- R3: The output of a phase is registered. It goes high on the edge after its counter reaches a value greater than or equal to 256 − duty, with the threshold computed in 9 bits. A duty value d gives exactly d high cycles in every 256.
- R4: Duty 0 keeps all outputs constantly low. Duty 255 gives one low cycle per 256.
- R5: Phase 2 starts when the counter of phase 1 equals 85, which is 256/3 rounded down. Its counter then trails the phase 1 counter by exactly 85 cycles, so the first rising edge of `pwm_out[1]` comes 85 cycles after that of `pwm_out[0]`.
- R6: Phase 3 starts from phase 2 under the same rule. Its first rising edge comes 170 cycles after that of phase 1.
- R7: Once a phase has started, it keeps running through all later passes of the previous counter. Only reset or a low `en` stops it.
- R8: When `en` is low at a clock edge, all counters, start flags and outputs clear at that edge. Raising `en` again restarts the staggered start-up from zero.
- R9: A phase that has not started yet holds its output low, whatever the duty value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global run enable; low clears all state |
| duty | input | 8 | High cycles per 256-cycle period, shared by all phases |
| pwm_out | output | 3 | Registered PWM outputs; bit 0 is phase 1, bit 2 is phase 3 |

## Verification
The hardest condition to reach from the ports is the staggered steady state. In it, phase 3 has started, every counter has wrapped at least once, and the duty word changes while all three counters are at different points of their periods. That state only exists after more than 170 enabled cycles. The stimulus holds `en` high for runs of several hundred cycles. Inside each run it changes the duty at random cycles, and between runs it drops `en` or pulses reset to restart the start-up chain. A cycle-exact bench model of the counters predicts every output bit.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;

    localparam int unsigned DEF_CNT_W  = 8;
    localparam int unsigned DEF_PHASES = 3;

    // Counter value at which the next phase is released.
    function automatic int unsigned start_mark(int unsigned cnt_w, int unsigned phases);
        return (32'd1 << cnt_w) / phases;
    endfunction

endpackage

// File: rtl/pwm_phase_core.sv
module pwm_phase_core #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o
);
    localparam logic [CNT_W:0] RANGE = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pwm;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CNT_W:0] thr_d;

    always_comb begin
        st_d  = st_q;
        thr_d = RANGE - {1'b0, duty};
        if (!en) begin
            st_d = '0;
        end else begin
            if (run) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.pwm = ({1'b0, st_q.cnt} >= thr_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign pwm_o = st_q.pwm;
endmodule

// File: rtl/pwm_start_hold.sv
module pwm_start_hold #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned MARK  = 85
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] prev_cnt,
    output logic             run_o,
    output logic             held_o
);
    localparam logic [CNT_W-1:0] MARK_V = MARK[CNT_W-1:0];

    typedef struct packed {
        logic held;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     hit_d;

    always_comb begin
        hit_d        = (prev_cnt == MARK_V);
        st_d.held    = en & (st_q.held | hit_d);
        // The release cycle itself already advances the counter, so the lag is exactly MARK.
        run_o        = st_q.held | hit_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o = st_q.held;
endmodule

// File: rtl/pwm_stagger.sv
module pwm_stagger #(
    parameter int unsigned CNT_W  = pwm_stagger_pkg::DEF_CNT_W,
    parameter int unsigned PHASES = pwm_stagger_pkg::DEF_PHASES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] duty,
    output logic [PHASES-1:0] pwm_out
);
    localparam int unsigned MARK = pwm_stagger_pkg::start_mark(CNT_W, PHASES);

    logic [PHASES-1:0][CNT_W-1:0] cnt_all;
    logic [PHASES-1:0]            run_all;
    logic [PHASES-1:0]            held_all;

    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        if (g == 0) begin : g_lead
            assign run_all[g]  = 1'b1;
            assign held_all[g] = 1'b1;
        end else begin : g_follow
            pwm_start_hold #(
                .CNT_W (CNT_W),
                .MARK  (MARK)
            ) u_hold (
                .clk      (clk),
                .rst      (rst),
                .en       (en),
                .prev_cnt (cnt_all[g-1]),
                .run_o    (run_all[g]),
                .held_o   (held_all[g])
            );
        end

        pwm_phase_core #(
            .CNT_W (CNT_W)
        ) u_core (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .run   (run_all[g]),
            .duty  (duty),
            .cnt_o (cnt_all[g]),
            .pwm_o (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_stagger_chk.sv
module pwm_stagger_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PHASES = 3,
    parameter int unsigned MARK   = 85
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         en,
    input logic [CNT_W-1:0]             duty,
    input logic [PHASES-1:0]            pwm_out,
    input logic [PHASES-1:0][CNT_W-1:0] cnt_all,
    input logic [PHASES-1:0]            held_all
);
    localparam logic [CNT_W-1:0] MARK_V = MARK[CNT_W-1:0];

    // R8
    en_low_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_out == '0));

    // R4
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |=> (pwm_out == '0));

    // R2
    lead_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt_all[0] == $past(cnt_all[0]) + 1'b1));

    for (genvar k = 1; k < PHASES; k++) begin : g_chk
        // R7
        start_held_chk: assert property (@(posedge clk) disable iff (rst)
            (en && held_all[k]) |=> held_all[k]);

        // R5
        idle_until_mark_chk: assert property (@(posedge clk) disable iff (rst)
            (en && !held_all[k] && cnt_all[k-1] != MARK_V) |=> (cnt_all[k] == '0));
    end
endmodule

bind pwm_stagger pwm_stagger_chk #(
    .CNT_W  (CNT_W),
    .PHASES (PHASES),
    .MARK   (MARK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .duty     (duty),
    .pwm_out  (pwm_out),
    .cnt_all  (cnt_all),
    .held_all (held_all)
);

// File: tb/sim_pwm_stagger.sv
module sim_pwm_stagger;
    localparam int SPACING = 85;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] duty = 8'd0;
    logic [2:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    int cycles = 0;

    pwm_stagger u0 (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .duty    (duty),
        .pwm_out (pwm_out)
    );

    always #10 clk = ~clk;

    function automatic int cnt_at(int p, int n);
        if (n < p * SPACING) return 0;
        return (n - p * SPACING) % 256;
    endfunction

    function automatic logic exp_bit(int p, int tt, int d);
        if (tt == 0) return 1'b0;
        return logic'(cnt_at(p, tt - 1) >= 256 - d);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0d duty=%0d)", req, act, exp, t, duty);
        end
    endtask

    task automatic tick(string req);
        @(posedge clk);
        @(negedge clk);
        if (rst || !en) t = 0;
        else t++;
        for (int p = 0; p < 3; p++) begin
            check(req, int'(pwm_out[p]), int'(exp_bit(p, t, int'(duty))));
        end
    endtask

    task automatic restart(logic use_rst);
        if (use_rst) rst = 1'b1;
        else en = 1'b0;
        tick("R1 R8 clear");
        rst = 1'b0;
        en  = 1'b1;
    endtask

    // Runs from a clean start and checks edge timing and high counts.
    task automatic directed_run(int d);
        int first_rise [3];
        int highs [3];
        logic prev [3];
        restart(1'b1);
        duty = d[7:0];
        for (int p = 0; p < 3; p++) begin
            first_rise[p] = -1;
            highs[p] = 0;
            prev[p] = 1'b0;
        end
        for (int i = 0; i < 300 + 256; i++) begin
            tick(i < 2 * SPACING ? "R9 idle phases" : "R3 compare");
            for (int p = 0; p < 3; p++) begin
                if (pwm_out[p] && !prev[p] && first_rise[p] < 0) first_rise[p] = t;
                prev[p] = pwm_out[p];
                if (t > 300 && t <= 556 && pwm_out[p]) highs[p]++;
            end
        end
        for (int p = 0; p < 3; p++) begin
            check("R3 high cycles per 256", highs[p], d);
        end
        if (d != 0) begin
            check("R5 phase 2 lag", first_rise[1] - first_rise[0], SPACING);
            check("R6 phase 3 lag", first_rise[2] - first_rise[0], 2 * SPACING);
        end else begin
            check("R4 duty 0 no edge", first_rise[0], -1);
        end
    endtask

    initial begin
        void'($urandom(32'd7421));
        @(negedge clk);
        tick("R1 reset");
        check("R1 reset state", int'(pwm_out), 0);
        rst = 1'b0;
        tick("R1 after reset, en low");
        check("R8 en low output", int'(pwm_out), 0);

        en = 1'b1;
        directed_run(128);
        directed_run(37);
        directed_run(0);
        directed_run(255);
        directed_run(1);

        // Random runs: duty changes mid-period, restarts by en or reset.
        for (int r = 0; r < 14; r++) begin
            int len;
            restart(r % 3 == 0);
            duty = 8'($urandom_range(0, 255));
            len = int'($urandom_range(60, 800));
            for (int i = 0; i < len; i++) begin
                if ($urandom_range(0, 99) < 3) duty = 8'($urandom_range(0, 255));
                tick(t > 256 ? "R7 R2 steady" : "R5 R6 start-up");
            end
        end

        // Dropping en late in a run clears everything at once.
        restart(1'b0);
        duty = 8'd200;
        for (int i = 0; i < 400; i++) tick("R7 run");
        en = 1'b0;
        tick("R8 en drop");
        check("R8 outputs cleared", int'(pwm_out), 0);
        en = 1'b1;
        for (int i = 0; i < 120; i++) tick("R8 restart");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end
endmodule